// File: doc/BRIEF.md
# PCIe Function-Reset Outbound Request Gate

This block sits between a device's internal fabric and a PCIe core, on the path that carries transactions the device masters toward the link. It keeps one stop bit for each physical function (three by default). Hardware sets a function's bit when that function enters function level reset. Software clears the bit once it knows the reset has finished. While the bit is set, any posted or non-posted request issued on behalf of that function, or on behalf of one of its virtual functions, is discarded before it reaches the core.

A discarded non-posted request is answered straight away with a locally built completion that carries an error status and the original tag. The requester therefore never waits on a timeout. Every discard marks an error flag for the function concerned and drives a level interrupt. Completions issued by the device, and traffic arriving from the link, pass through the block untouched.

The stop bits follow the MAC reset only. A soft reset clears the pipeline and the error flags but leaves the stop bits as they were, so a function that is still resetting stays fenced.

Top module: `flr_req_gate`

## Requirements
- R1: After MAC reset the stop bits and error flags are zero, `errIrq` is low, and none of the three output valids is asserted. Both register reads return zero in all 64 bits, and bits 63:3 always read zero.
- R2: A pulse on `flrEnter[p]` sets stop bit p at that clock edge. The bit then reads as 1 through `regAddr`=0 (stop register, bit p = function p).
- R3: Writing the stop register (`regWrEn`=1, `regAddr`=0) clears each bit whose `regWrData` bit is 1. Bits written with 0 keep their value. Nothing else clears a stop bit, apart from MAC reset.
- R4: A request (`reqType` 2'b00 posted or 2'b01 non-posted) whose `reqPf` names a function with its stop bit set produces no `outValid` on the next cycle, whatever `reqIsVf` is. Other requests appear on the out port one cycle later with unchanged fields. The decision uses the stop bits as they stood before the edge, so a request in the same cycle as `flrEnter` still passes. A `reqPf` of 3 names no function and is never stopped.
- R5: A dropped non-posted request raises `cplValid` one cycle later, carrying the same `cplTag`, `cplPf` and `cplIsVf` and a `cplStatus` of 3'b001. A dropped posted request produces no completion.
- R6: Each drop sets error flag p for the function concerned (read through `regAddr`=1, bit p). `errIrq` is high while any flag is set. A flag stays set until software writes 1 to its bit at `regAddr`=1.
- R7: Completions (`reqType` 2'b10) and reserved type 2'b11 are always forwarded. Inbound traffic (`inValid`/`inData`) appears on `inOutValid`/`inOutData` one cycle later. Neither of these is affected by the stop bits.
- R8: While `softRstN` is low, the stop bits keep their value, while the error flags and all output valids are cleared. Asserting `macRstN` clears the stop bits.
- R9: If an FLR entry and a software clear reach the same stop bit in the same cycle, the bit ends up set. The same rule holds for an error flag that is set by a drop while being cleared by software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| macRstN | input | 1 | Asynchronous active-low MAC reset; clears everything |
| softRstN | input | 1 | Asynchronous active-low soft reset; keeps the stop bits |
| flrEnter | input | 3 | One-cycle pulse per function entering function level reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 stop bits, 1 error flags |
| regWrData | input | 3 | Write-one-to-clear mask for the selected register |
| regRdData | output | 64 | Combinational read of the selected register |
| errIrq | output | 1 | Level interrupt, high while any error flag is set |
| reqValid | input | 1 | Outbound transaction valid |
| reqType | input | 2 | 00 posted, 01 non-posted, 10 completion, 11 reserved |
| reqPf | input | 2 | Physical function that owns the transaction |
| reqIsVf | input | 1 | Transaction belongs to a child VF of `reqPf` |
| reqTag | input | 8 | Transaction tag |
| reqData | input | 32 | Transaction payload |
| outValid | output | 1 | Forwarded transaction valid toward the core |
| outType | output | 2 | Forwarded type |
| outPf | output | 2 | Forwarded function number |
| outIsVf | output | 1 | Forwarded VF marker |
| outTag | output | 8 | Forwarded tag |
| outData | output | 32 | Forwarded payload |
| cplValid | output | 1 | Local error completion valid |
| cplPf | output | 2 | Function of the rejected request |
| cplIsVf | output | 1 | VF marker of the rejected request |
| cplTag | output | 8 | Tag of the rejected request |
| cplStatus | output | 3 | Completion status, always 3'b001 |
| inValid | input | 1 | Inbound transaction valid |
| inData | input | 32 | Inbound payload |
| inOutValid | output | 1 | Inbound transaction valid toward the fabric |
| inOutData | output | 32 | Inbound payload toward the fabric |

## Verification
The stop bits, the error flags and the three output streams each settle at the first rising edge after their stimulus, so every result is due one cycle later. Register reads and `errIrq` follow the flags without a further register, so they are valid at that same point. The bench changes inputs only on falling edges and reads results on the next falling edge, which puts every check half a cycle after the edge that produced it. The same-cycle cases (FLR entry together with a request, or together with a clear) are driven in one falling-edge slot so that they reach the same rising edge.

// File: rtl/flr_gate_pkg.sv
package flr_gate_pkg;

  typedef enum logic [1:0] {
    TXN_POSTED    = 2'b00,
    TXN_NONPOSTED = 2'b01,
    TXN_CPL       = 2'b10,
    TXN_RSVD      = 2'b11
  } txnType_e;

  // control -> datapath strobes
  typedef struct packed {
    logic fwd;
    logic drop;
    logic genCpl;
    logic inPass;
  } gateStrobe_t;

  localparam logic       REG_SEL_STOP   = 1'b0;
  localparam logic       REG_SEL_ERR    = 1'b1;
  localparam logic [2:0] CPL_STATUS_ERR = 3'b001;

endpackage

// File: rtl/flr_gate_ctrl.sv
module flr_gate_ctrl
  import flr_gate_pkg::*;
#(
  parameter int NUM_PF = 3,
  parameter int PF_W   = 2,
  parameter int REG_W  = 64
) (
  input  logic              clk,
  input  logic              stickyRstN,
  input  logic              coreRstN,
  input  logic [NUM_PF-1:0] flrEnter,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [NUM_PF-1:0] regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              errIrq,
  input  logic              reqValid,
  input  logic [1:0]        reqType,
  input  logic [PF_W-1:0]   reqPf,
  input  logic              inValid,
  output gateStrobe_t       strobe
);

  logic [NUM_PF-1:0] stopReg;
  logic [NUM_PF-1:0] errFlag;
  logic [NUM_PF-1:0] dropHit;
  logic              isReq;
  logic              reqStopped;
  logic              dropNow;

  assign isReq = reqValid && (reqType == TXN_POSTED || reqType == TXN_NONPOSTED);

  always_comb begin
    reqStopped = 1'b0;
    for (int p = 0; p < NUM_PF; p++) begin
      if (reqPf == PF_W'(p) && stopReg[p]) reqStopped = 1'b1;
    end
  end

  assign dropNow = isReq && reqStopped;

  for (genvar p = 0; p < NUM_PF; p++) begin : g_pf
    logic stopBit;
    logic errBit;
    logic stopClr;
    logic errClr;

    assign stopClr    = regWrEn && (regAddr == REG_SEL_STOP) && regWrData[p];
    assign errClr     = regWrEn && (regAddr == REG_SEL_ERR) && regWrData[p];
    assign dropHit[p] = dropNow && (reqPf == PF_W'(p));

    // hardware set has priority over the software clear
    always_ff @(posedge clk or negedge stickyRstN) begin
      if (!stickyRstN)      stopBit <= 1'b0;
      else if (flrEnter[p]) stopBit <= 1'b1;
      else if (stopClr)     stopBit <= 1'b0;
    end

    always_ff @(posedge clk or negedge coreRstN) begin
      if (!coreRstN)       errBit <= 1'b0;
      else if (dropHit[p]) errBit <= 1'b1;
      else if (errClr)     errBit <= 1'b0;
    end

    assign stopReg[p] = stopBit;
    assign errFlag[p] = errBit;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == REG_SEL_ERR) regRdData[NUM_PF-1:0] = errFlag;
    else                        regRdData[NUM_PF-1:0] = stopReg;
  end

  assign errIrq = |errFlag;

  always_comb begin
    strobe.drop   = dropNow;
    strobe.fwd    = reqValid && !dropNow;
    strobe.genCpl = dropNow && (reqType == TXN_NONPOSTED);
    strobe.inPass = inValid;
  end

  // R2
  flr_sets_stop_chk: assert property (@(posedge clk) disable iff (!stickyRstN)
    (flrEnter != '0) |=> ((stopReg & $past(flrEnter)) == $past(flrEnter)));

  // R3
  w1c_stop_chk: assert property (@(posedge clk) disable iff (!stickyRstN)
    (regWrEn && regAddr == REG_SEL_STOP && flrEnter == '0)
      |=> (stopReg == ($past(stopReg) & ~$past(regWrData))));

  // R6
  drop_raises_irq_chk: assert property (@(posedge clk) disable iff (!coreRstN)
    dropNow |=> errIrq);

  // R6
  irq_holds_chk: assert property (@(posedge clk) disable iff (!coreRstN)
    (errIrq && !regWrEn) |=> errIrq);

  // R8
  soft_keeps_stop_chk: assert property (@(posedge clk) disable iff (!stickyRstN)
    (!coreRstN && flrEnter == '0 && !(regWrEn && regAddr == REG_SEL_STOP))
      |=> $stable(stopReg));

endmodule

// File: rtl/flr_gate_dp.sv
module flr_gate_dp
  import flr_gate_pkg::*;
#(
  parameter int PF_W   = 2,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  parameter int IN_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic [1:0]        reqType,
  input  logic [PF_W-1:0]   reqPf,
  input  logic              reqIsVf,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [DATA_W-1:0] reqData,
  input  logic [IN_W-1:0]   inData,
  output logic              outValid,
  output logic [1:0]        outType,
  output logic [PF_W-1:0]   outPf,
  output logic              outIsVf,
  output logic [TAG_W-1:0]  outTag,
  output logic [DATA_W-1:0] outData,
  output logic              cplValid,
  output logic [PF_W-1:0]   cplPf,
  output logic              cplIsVf,
  output logic [TAG_W-1:0]  cplTag,
  output logic [2:0]        cplStatus,
  output logic              inOutValid,
  output logic [IN_W-1:0]   inOutData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      cplValid   <= 1'b0;
      inOutValid <= 1'b0;
    end else begin
      outValid   <= strobe.fwd;
      cplValid   <= strobe.genCpl;
      inOutValid <= strobe.inPass;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outType <= '0;
      outPf   <= '0;
      outIsVf <= 1'b0;
      outTag  <= '0;
      outData <= '0;
    end else if (strobe.fwd) begin
      outType <= reqType;
      outPf   <= reqPf;
      outIsVf <= reqIsVf;
      outTag  <= reqTag;
      outData <= reqData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cplPf     <= '0;
      cplIsVf   <= 1'b0;
      cplTag    <= '0;
      cplStatus <= '0;
    end else if (strobe.genCpl) begin
      cplPf     <= reqPf;
      cplIsVf   <= reqIsVf;
      cplTag    <= reqTag;
      cplStatus <= CPL_STATUS_ERR;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              inOutData <= '0;
    else if (strobe.inPass) inOutData <= inData;
  end

  // R4
  drop_blocks_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.drop |=> !outValid);

  // R5
  cpl_matches_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.genCpl |=> (cplValid && cplTag == $past(reqTag) && cplStatus == CPL_STATUS_ERR));

  // R5
  posted_no_cpl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drop && !strobe.genCpl) |=> !cplValid);

endmodule

// File: rtl/flr_req_gate.sv
module flr_req_gate
  import flr_gate_pkg::*;
#(
  parameter int NUM_PF = 3,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  parameter int IN_W   = 32,
  parameter int REG_W  = 64,
  localparam int PF_W  = (NUM_PF > 1) ? $clog2(NUM_PF) : 1
) (
  input  logic              clk,
  input  logic              macRstN,
  input  logic              softRstN,
  input  logic [NUM_PF-1:0] flrEnter,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [NUM_PF-1:0] regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              errIrq,
  input  logic              reqValid,
  input  logic [1:0]        reqType,
  input  logic [PF_W-1:0]   reqPf,
  input  logic              reqIsVf,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [DATA_W-1:0] reqData,
  output logic              outValid,
  output logic [1:0]        outType,
  output logic [PF_W-1:0]   outPf,
  output logic              outIsVf,
  output logic [TAG_W-1:0]  outTag,
  output logic [DATA_W-1:0] outData,
  output logic              cplValid,
  output logic [PF_W-1:0]   cplPf,
  output logic              cplIsVf,
  output logic [TAG_W-1:0]  cplTag,
  output logic [2:0]        cplStatus,
  input  logic              inValid,
  input  logic [IN_W-1:0]   inData,
  output logic              inOutValid,
  output logic [IN_W-1:0]   inOutData
);

  logic        coreRstN;
  gateStrobe_t strobe;

  assign coreRstN = macRstN & softRstN;

  flr_gate_ctrl #(
    .NUM_PF(NUM_PF), .PF_W(PF_W), .REG_W(REG_W)
  ) u_ctrl (
    .clk        (clk),
    .stickyRstN (macRstN),
    .coreRstN   (coreRstN),
    .flrEnter   (flrEnter),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .errIrq     (errIrq),
    .reqValid   (reqValid),
    .reqType    (reqType),
    .reqPf      (reqPf),
    .inValid    (inValid),
    .strobe     (strobe)
  );

  flr_gate_dp #(
    .PF_W(PF_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .IN_W(IN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (coreRstN),
    .strobe     (strobe),
    .reqType    (reqType),
    .reqPf      (reqPf),
    .reqIsVf    (reqIsVf),
    .reqTag     (reqTag),
    .reqData    (reqData),
    .inData     (inData),
    .outValid   (outValid),
    .outType    (outType),
    .outPf      (outPf),
    .outIsVf    (outIsVf),
    .outTag     (outTag),
    .outData    (outData),
    .cplValid   (cplValid),
    .cplPf      (cplPf),
    .cplIsVf    (cplIsVf),
    .cplTag     (cplTag),
    .cplStatus  (cplStatus),
    .inOutValid (inOutValid),
    .inOutData  (inOutData)
  );

  // R7
  cpl_passthru_chk: assert property (@(posedge clk) disable iff (!coreRstN)
    (reqValid && reqType == TXN_CPL) |=> (outValid && outTag == $past(reqTag)));

  // R7
  inbound_passthru_chk: assert property (@(posedge clk) disable iff (!coreRstN)
    inValid |=> (inOutValid && inOutData == $past(inData)));

endmodule

// File: tb/flr_req_gate_tb.sv
module flr_req_gate_tb;

  logic        clk = 1'b0;
  logic        macRstN, softRstN;
  logic [2:0]  flrEnter;
  logic        regWrEn, regAddr;
  logic [2:0]  regWrData;
  logic [63:0] regRdData;
  logic        errIrq;
  logic        reqValid, reqIsVf;
  logic [1:0]  reqType, reqPf;
  logic [7:0]  reqTag;
  logic [31:0] reqData;
  logic        outValid, outIsVf;
  logic [1:0]  outType, outPf;
  logic [7:0]  outTag;
  logic [31:0] outData;
  logic        cplValid, cplIsVf;
  logic [1:0]  cplPf;
  logic [7:0]  cplTag;
  logic [2:0]  cplStatus;
  logic        inValid, inOutValid;
  logic [31:0] inData, inOutData;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #5 clk = ~clk;

  flr_req_gate u_dut (
    .clk(clk), .macRstN(macRstN), .softRstN(softRstN), .flrEnter(flrEnter),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .errIrq(errIrq),
    .reqValid(reqValid), .reqType(reqType), .reqPf(reqPf), .reqIsVf(reqIsVf),
    .reqTag(reqTag), .reqData(reqData),
    .outValid(outValid), .outType(outType), .outPf(outPf), .outIsVf(outIsVf),
    .outTag(outTag), .outData(outData),
    .cplValid(cplValid), .cplPf(cplPf), .cplIsVf(cplIsVf), .cplTag(cplTag),
    .cplStatus(cplStatus),
    .inValid(inValid), .inData(inData), .inOutValid(inOutValid), .inOutData(inOutData)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readReg(input logic sel, output logic [63:0] val);
    regAddr = sel;
    #1;
    val = regRdData;
  endtask

  task automatic w1c(input logic sel, input logic [2:0] mask);
    regWrEn = 1'b1; regAddr = sel; regWrData = mask;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finishRun();
    end
  end

  initial begin
    logic [63:0] rd;
    macRstN = 0; softRstN = 0; flrEnter = '0; regWrEn = 0; regAddr = 0; regWrData = '0;
    reqValid = 0; reqType = '0; reqPf = '0; reqIsVf = 0; reqTag = '0; reqData = '0;
    inValid = 0; inData = '0;
    repeat (3) @(negedge clk);
    macRstN = 1; softRstN = 1;
    tick();

    // R1 reset state
    readReg(1'b0, rd); chk("R1", "stop reg after reset", rd, 0);
    readReg(1'b1, rd); chk("R1", "err reg after reset", rd, 0);
    chk("R1", "errIrq", errIrq, 0);
    chk("R1", "valids", {outValid, cplValid, inOutValid}, 0);

    // R2 FLR entry sets bit
    flrEnter = 3'b010; tick(); flrEnter = '0;
    readReg(1'b0, rd); chk("R2", "stop after flr pf1", rd, 64'h2);

    // R9 set wins over simultaneous clear
    flrEnter = 3'b001; regWrEn = 1; regAddr = 0; regWrData = 3'b011;
    tick(); flrEnter = '0; regWrEn = 0; regWrData = '0;
    readReg(1'b0, rd); chk("R9", "set wins / clear bit1", rd, 64'h1);

    // R3 writing zero has no effect, writing one clears
    w1c(1'b0, 3'b000);
    readReg(1'b0, rd); chk("R3", "w0 keeps", rd, 64'h1);
    w1c(1'b1, 3'b111);
    readReg(1'b0, rd); chk("R3", "err-reg write keeps stop", rd, 64'h1);
    w1c(1'b0, 3'b001);
    readReg(1'b0, rd); chk("R3", "w1 clears", rd, 64'h0);

    // R4 request in the FLR cycle passes, the next is dropped
    flrEnter = 3'b100; reqValid = 1; reqType = 2'b00; reqPf = 2'd2; reqTag = 8'h5A; reqData = 32'hCAFE0001;
    tick(); flrEnter = '0;
    chk("R4", "same-cycle request forwarded", outValid, 1);
    chk("R4", "same-cycle tag", outTag, 8'h5A);
    reqTag = 8'h5B;
    tick(); reqValid = 0;
    chk("R4", "stopped posted dropped", outValid, 0);
    chk("R5", "posted drop no cpl", cplValid, 0);
    readReg(1'b1, rd); chk("R6", "err flag pf2", rd, 64'h4);

    // R6 level interrupt holds until W1C of its bit
    repeat (3) tick();
    chk("R6", "irq held", errIrq, 1);
    w1c(1'b1, 3'b011);
    chk("R6", "irq kept by other bits clear", errIrq, 1);
    w1c(1'b0, 3'b000);
    chk("R6", "irq kept by stop-reg write", errIrq, 1);
    // R9 drop and clear of the same error flag together
    reqValid = 1; reqType = 2'b01; reqPf = 2'd2; reqTag = 8'h33;
    regWrEn = 1; regAddr = 1; regWrData = 3'b100;
    tick(); reqValid = 0; regWrEn = 0; regWrData = '0;
    readReg(1'b1, rd); chk("R9", "err set wins", rd, 64'h4);
    chk("R5", "np drop cpl", cplValid, 1);
    chk("R5", "np cpl tag", cplTag, 8'h33);
    w1c(1'b1, 3'b100);
    chk("R6", "irq cleared", errIrq, 0);

    // R8 soft reset keeps stop bits, clears err flags
    flrEnter = 3'b101; tick(); flrEnter = '0;
    reqValid = 1; reqType = 2'b00; reqPf = 2'd0; tick(); reqValid = 0;
    chk("R8", "irq before soft reset", errIrq, 1);
    softRstN = 0; tick(); tick();
    readReg(1'b0, rd); chk("R8", "stop kept in soft reset", rd, 64'h7 & 64'h5);
    readReg(1'b1, rd); chk("R8", "err cleared in soft reset", rd, 0);
    chk("R8", "irq low", errIrq, 0);
    softRstN = 1; tick();
    readReg(1'b0, rd); chk("R8", "stop kept after soft reset", rd, 64'h5);
    macRstN = 0; tick(); macRstN = 1; tick();
    readReg(1'b0, rd); chk("R8", "mac reset clears stop", rd, 0);

    // sweep: every stop mask x function x VF marker x type
    for (int mask = 0; mask < 8; mask++) begin
      w1c(1'b0, 3'b111);
      flrEnter = mask[2:0]; tick(); flrEnter = '0;
      readReg(1'b0, rd); chk("R2", "sweep stop mask", rd, mask);
      for (int pf = 0; pf < 4; pf++) begin
        for (int vf = 0; vf < 2; vf++) begin
          for (int ty = 0; ty < 4; ty++) begin
            bit         stopped, drop;
            logic [7:0] tag;
            logic [31:0] dat;
            tag = 8'((mask * 32) + (pf * 8) + (vf * 4) + ty);
            dat = 32'h1000_0000 + 32'(tag) * 32'd977;
            stopped = (pf < 3) && mask[pf];
            drop = (ty < 2) && stopped;
            reqValid = 1; reqType = 2'(ty); reqPf = 2'(pf); reqIsVf = vf[0];
            reqTag = tag; reqData = dat;
            inValid = 1; inData = ~dat;
            tick();
            reqValid = 0; inValid = 0;
            chk(drop ? "R4" : "R7", "outValid", outValid, !drop);
            if (!drop) begin
              chk("R4", "outTag", outTag, tag);
              chk("R4", "outData", outData, dat);
              chk("R4", "outType/Pf/IsVf", {outType, outPf, outIsVf}, {2'(ty), 2'(pf), vf[0]});
            end
            chk("R5", "cplValid", cplValid, drop && ty == 1);
            if (drop && ty == 1)
              chk("R5", "cpl fields", {cplTag, cplPf, cplIsVf, cplStatus},
                  {tag, 2'(pf), vf[0], 3'b001});
            readReg(1'b1, rd);
            chk("R6", "err flags", rd, drop ? (64'h1 << pf) : 64'h0);
            chk("R6", "errIrq", errIrq, drop);
            chk("R7", "inbound pass", {inOutValid, inOutData}, {1'b1, ~dat});
            w1c(1'b1, 3'b111);
          end
        end
      end
    end

    done = 1;
    finishRun();
  end

endmodule